// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the fetch address of a small 32-bit processor whose memory is addressed by byte and whose instructions are one 32-bit word each. In every cycle that is not stalled or halted, the instruction at the current fetch address is taken to execute. The unit then chooses the next address from one of four sources: the following word, a relative branch target, a value that an instruction writes to register number 0 (the counter itself), or an address loaded from outside.

The decode stage supplies the opcode, the destination field, the 9-bit branch offset and the two compare operands. The datapath supplies the write-back result. Any instruction that names the counter as a source receives the address of that instruction plus one word, and the unit provides this value on its own port. Interrupt entry and return are not part of this block. They reach it only through the external load port, which takes precedence over normal sequencing.

Top module: `pc_branch_unit`

## Requirements
- R1: While reset is low, `fetch_addr` is 0 and `fetch_req` is 0. Once reset is released, `fetch_req` is 1 while `halt` is 0.
- R2: An executed instruction that neither branches nor writes the counter moves `fetch_addr` up by 4. `pc_operand` always equals `fetch_addr` + 4.
- R3: Opcode 5'b01011 is the equal branch. When `opnd_x` equals `opnd_y`, the next address is `fetch_addr` + 4 + 4*off, where off is `br_imm[8:0]` read as two's complement. So off=0 falls through, off=-1 stays on the branch, off=-2 goes back one instruction, and the reach runs from -256 to +255 words.
- R4: Opcode 5'b01100 is the less-than branch. It uses the same target as R3 and is taken only when `opnd_x` < `opnd_y`, both compared as unsigned 32-bit values.
- R5: A branch that is not taken moves `fetch_addr` up by 4.
- R6: The opcodes that write their destination are 0 to 7, 9, 10 and 13. When one of these has `dst_reg` equal to 0, the next address is `wb_data`. With any other `dst_reg`, or with opcode 8, 14 or 15, the next address is `fetch_addr` + 4.
- R7: While `stall` is 1 and no external load is present, `fetch_addr` holds.
- R8: While `halt` is 1, `fetch_req` is 0 and `fetch_addr` holds. This holds even when `ext_load` is 1 or `stall` is 0.
- R9: When `ext_load` is 1 and `halt` is 0, the next address is `ext_addr`. This takes precedence over stall, branches and write-back.
- R10: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold the current instruction without executing it |
| halt | input | 1 | Freeze the counter and stop fetching |
| ext_load | input | 1 | Load `ext_addr` into the counter |
| ext_addr | input | 32 | Address for an external load |
| opcode | input | 5 | Opcode of the instruction at `fetch_addr` |
| dst_reg | input | 9 | Destination register number |
| br_imm | input | 9 | Signed branch offset in words |
| opnd_x | input | 32 | First compare operand |
| opnd_y | input | 32 | Second compare operand |
| wb_data | input | 32 | Result written to the destination register |
| fetch_addr | output | 32 | Current fetch address |
| fetch_req | output | 1 | Fetch request |
| pc_operand | output | 32 | Value the counter presents as a source operand |

## Verification
The equal branch is run with all 512 offsets from a fixed base, both taken and not taken. This separates sign extension, word scaling and the +4 bias, and it covers the extremes +255 and -256 as well as 0 and -1. The less-than branch is tried with operand pairs on either side of bit 31 and with equal pairs. A signed compare, or a compare that allows equality, would fail these pairs.

All sixteen opcodes are run with a destination of 0 and with a destination other than 0. This separates the opcodes that write the counter from stores, branches and reserved codes. Stall, halt and external load are then applied together to confirm their order of precedence, and the stepping and branching are repeated at the top and bottom of the address space to confirm the wrap.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int OPC_W = 5;

    localparam logic [OPC_W-1:0] OPC_STORE  = 5'd8;
    localparam logic [OPC_W-1:0] OPC_BR_EQ  = 5'd11;
    localparam logic [OPC_W-1:0] OPC_BR_LTU = 5'd12;
    localparam logic [OPC_W-1:0] OPC_LDIMM  = 5'd13;

    typedef enum logic [1:0] {
        SRC_SEQ,
        SRC_BRANCH,
        SRC_WRITE,
        SRC_EXT
    } pc_src_e;

    // Opcodes whose first register field is a destination that is written.
    function automatic logic writes_dest(input logic [OPC_W-1:0] op);
        return ((op <= 5'd10) && (op != OPC_STORE)) || (op == OPC_LDIMM);
    endfunction

endpackage

// File: rtl/pcb_compare.sv
module pcb_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              is_eq,
    output logic              is_ltu
);
    always_comb begin
        is_eq  = (a == b);
        is_ltu = (a < b);
    end
endmodule

// File: rtl/pcb_incr.sv
module pcb_incr #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    always_comb next_addr = addr + STEP;
endmodule

// File: rtl/pcb_target.sv
module pcb_target #(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 9,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [IMM_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);
    localparam int SHIFT = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] ext_off;

    always_comb begin
        ext_off = {{(ADDR_W-IMM_W){offset[IMM_W-1]}}, offset};
        target  = seq_addr + (ext_off << SHIFT);
    end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
    parameter int ADDR_W     = 32,
    parameter int REG_W      = 9,
    parameter int IMM_W      = 9,
    parameter int WORD_BYTES = 4,
    parameter int PC_REG     = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stall,
    input  logic                     halt,
    input  logic                     ext_load,
    input  logic [ADDR_W-1:0]        ext_addr,
    input  logic [pcb_pkg::OPC_W-1:0] opcode,
    input  logic [REG_W-1:0]         dst_reg,
    input  logic [IMM_W-1:0]         br_imm,
    input  logic [ADDR_W-1:0]        opnd_x,
    input  logic [ADDR_W-1:0]        opnd_y,
    input  logic [ADDR_W-1:0]        wb_data,
    output logic [ADDR_W-1:0]        fetch_addr,
    output logic                     fetch_req,
    output logic [ADDR_W-1:0]        pc_operand
);
    import pcb_pkg::*;

    localparam logic [REG_W-1:0] PC_SEL = REG_W'(PC_REG);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } state_t;

    state_t state_d, state_q;

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_target;
    logic              ops_eq;
    logic              ops_ltu;
    logic              br_taken;
    logic              pc_written;
    pc_src_e           src;

    pcb_incr #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_incr (
        .addr      (state_q.pc),
        .next_addr (seq_addr)
    );

    pcb_target #(
        .ADDR_W     (ADDR_W),
        .IMM_W      (IMM_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_target (
        .seq_addr (seq_addr),
        .offset   (br_imm),
        .target   (br_target)
    );

    pcb_compare #(
        .DATA_W (ADDR_W)
    ) u_cmp (
        .a      (opnd_x),
        .b      (opnd_y),
        .is_eq  (ops_eq),
        .is_ltu (ops_ltu)
    );

    always_comb begin
        br_taken   = ((opcode == OPC_BR_EQ)  && ops_eq) ||
                     ((opcode == OPC_BR_LTU) && ops_ltu);
        pc_written = writes_dest(opcode) && (dst_reg == PC_SEL);

        if (ext_load)        src = SRC_EXT;
        else if (br_taken)   src = SRC_BRANCH;
        else if (pc_written) src = SRC_WRITE;
        else                 src = SRC_SEQ;

        state_d = state_q;
        if (!halt && (ext_load || !stall)) begin
            unique case (src)
                SRC_EXT:    state_d.pc = ext_addr;
                SRC_BRANCH: state_d.pc = br_target;
                SRC_WRITE:  state_d.pc = wb_data;
                default:    state_d.pc = seq_addr;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign fetch_addr = state_q.pc;
    assign pc_operand = seq_addr;
    assign fetch_req  = rst_n && !halt;

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      stall,
    input logic                      halt,
    input logic                      ext_load,
    input logic [ADDR_W-1:0]         ext_addr,
    input logic [pcb_pkg::OPC_W-1:0] opcode,
    input logic [ADDR_W-1:0]         opnd_x,
    input logic [ADDR_W-1:0]         opnd_y,
    input logic [ADDR_W-1:0]         fetch_addr
);
    import pcb_pkg::*;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> fetch_addr == '0);

    // R5
    not_taken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !ext_load && !stall && opcode == OPC_BR_EQ && opnd_x != opnd_y)
        |=> fetch_addr == $past(fetch_addr) + ADDR_W'(WORD_BYTES));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !ext_load) |=> $stable(fetch_addr));

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(fetch_addr));

    // R9
    ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_load && !halt) |=> fetch_addr == $past(ext_addr));

endmodule

bind pc_branch_unit pcb_checker #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
) u_pcb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .halt       (halt),
    .ext_load   (ext_load),
    .ext_addr   (ext_addr),
    .opcode     (opcode),
    .opnd_x     (opnd_x),
    .opnd_y     (opnd_y),
    .fetch_addr (fetch_addr)
);

// File: tb/pc_branch_unit_bench.sv
module pc_branch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic        halt;
    logic        ext_load;
    logic [31:0] ext_addr;
    logic [4:0]  opcode;
    logic [8:0]  dst_reg;
    logic [8:0]  br_imm;
    logic [31:0] opnd_x;
    logic [31:0] opnd_y;
    logic [31:0] wb_data;
    logic [31:0] fetch_addr;
    logic        fetch_req;
    logic [31:0] pc_operand;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] BASE = 32'h0000_4000;

    always #5 clk = ~clk;

    pc_branch_unit u_pc_branch_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall),
        .halt       (halt),
        .ext_load   (ext_load),
        .ext_addr   (ext_addr),
        .opcode     (opcode),
        .dst_reg    (dst_reg),
        .br_imm     (br_imm),
        .opnd_x     (opnd_x),
        .opnd_y     (opnd_y),
        .wb_data    (wb_data),
        .fetch_addr (fetch_addr),
        .fetch_req  (fetch_req),
        .pc_operand (pc_operand)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Load an address through the external port while stalled (R9).
    task automatic load_pc(input logic [31:0] addr);
        ext_load = 1'b1;
        ext_addr = addr;
        stall    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ext_load = 1'b0;
        check(fetch_addr, addr, "R9 external load");
    endtask

    // Execute one instruction and compare the next fetch address.
    task automatic exec(input logic [4:0] op, input logic [8:0] dst, input logic [8:0] imm,
                        input logic [31:0] x, input logic [31:0] y, input logic [31:0] wb,
                        input logic [31:0] exp, input string tag);
        opcode  = op;
        dst_reg = dst;
        br_imm  = imm;
        opnd_x  = x;
        opnd_y  = y;
        wb_data = wb;
        stall   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        stall   = 1'b1;
        check(fetch_addr, exp, tag);
    endtask

    function automatic logic [31:0] br_dest(input logic [31:0] pc, input logic [8:0] imm);
        return pc + 32'd4 + {{21{imm[8]}}, imm, 2'b00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] px [6];
        logic [31:0] py [6];
        rst_n = 1'b0; stall = 1'b1; halt = 1'b0; ext_load = 1'b0; ext_addr = '0;
        opcode = 5'd8; dst_reg = 9'd3; br_imm = '0; opnd_x = '0; opnd_y = '0; wb_data = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(fetch_addr, 32'h0, "R1 reset address");
        check({31'b0, fetch_req}, 32'h0, "R1 no fetch in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(fetch_addr, 32'h0, "R1 address after release");
        check({31'b0, fetch_req}, 32'h1, "R1 fetch after release");

        // R2: sequential stepping and operand value
        for (int i = 0; i < 4; i++) begin
            check(pc_operand, 32'(i * 4 + 4), "R2 operand is address plus 4");
            exec(5'd8, 9'd3, 9'd0, 32'd0, 32'd0, 32'd0, 32'(i * 4 + 4), "R2 step");
        end

        // R3: all 512 offsets taken (covers 0, -1, -2, +255, -256)
        for (int k = 0; k < 512; k++) begin
            load_pc(BASE);
            exec(5'b01011, 9'd3, 9'(k), 32'h1234_5678, 32'h1234_5678, 32'd0,
                 br_dest(BASE, 9'(k)), $sformatf("R3 taken off=%0d", $signed(9'(k))));
        end

        // R5: equal branch not taken for a sample of offsets
        for (int k = 0; k < 512; k += 37) begin
            load_pc(BASE);
            exec(5'b01011, 9'd3, 9'(k), 32'h8000_0000, 32'h0000_0000, 32'd0,
                 BASE + 32'd4, $sformatf("R5 not taken off=%0d", $signed(9'(k))));
        end

        // R4: unsigned compare across bit 31, offset -16
        px[0] = 32'h7FFF_FFFF; py[0] = 32'h8000_0000;
        px[1] = 32'h8000_0000; py[1] = 32'h7FFF_FFFF;
        px[2] = 32'hFFFF_FFFF; py[2] = 32'hFFFF_FFFF;
        px[3] = 32'h0000_0000; py[3] = 32'hFFFF_FFFF;
        px[4] = 32'hFFFF_FFFE; py[4] = 32'hFFFF_FFFF;
        px[5] = 32'h0000_0005; py[5] = 32'h0000_0005;
        for (int p = 0; p < 6; p++) begin
            load_pc(BASE);
            exec(5'b01100, 9'd3, 9'h1F0, px[p], py[p], 32'd0,
                 (px[p] < py[p]) ? BASE + 32'd4 - 32'd64 : BASE + 32'd4,
                 $sformatf("R4 ltu pair %0d", p));
        end

        // R6: every opcode with destination 0 and destination 7
        for (int op = 0; op < 16; op++) begin
            logic wr;
            wr = (op <= 10 && op != 8) || op == 13;
            load_pc(BASE);
            exec(5'(op), 9'd0, 9'd0, 32'h1, 32'h2, 32'hA000_0000 + 32'(op * 16),
                 wr ? 32'hA000_0000 + 32'(op * 16) : BASE + 32'd4,
                 $sformatf("R6 op=%0d dst=0", op));
            load_pc(BASE);
            exec(5'(op), 9'd7, 9'd0, 32'h1, 32'h2, 32'hA000_0000 + 32'(op * 16),
                 BASE + 32'd4, $sformatf("R6 op=%0d dst=7", op));
        end

        // R7: stall holds even with a taken branch presented
        load_pc(BASE);
        opcode = 5'b01011; br_imm = 9'd10; opnd_x = 32'd1; opnd_y = 32'd1; stall = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(fetch_addr, BASE, "R7 stall hold");

        // R8: halt freezes despite external load and no stall
        halt = 1'b1; stall = 1'b0; ext_load = 1'b1; ext_addr = 32'h0000_9000;
        @(negedge clk);
        check({31'b0, fetch_req}, 32'h0, "R8 no fetch while halted");
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(fetch_addr, BASE, "R8 halt freeze");
        ext_load = 1'b0; stall = 1'b1; halt = 1'b0;
        @(negedge clk);
        check({31'b0, fetch_req}, 32'h1, "R8 fetch resumes");

        // R9: external load beats a taken branch and a write to the counter
        opcode = 5'b01011; br_imm = 9'd10; opnd_x = 32'd1; opnd_y = 32'd1; stall = 1'b0;
        ext_load = 1'b1; ext_addr = 32'h0000_7777_0;
        @(posedge clk);
        @(negedge clk);
        ext_load = 1'b0; stall = 1'b1;
        check(fetch_addr, 32'h0007_7770, "R9 priority over branch");
        opcode = 5'd0; dst_reg = 9'd0; wb_data = 32'h5555_0000; stall = 1'b0;
        ext_load = 1'b1; ext_addr = 32'h0000_0100;
        @(posedge clk);
        @(negedge clk);
        ext_load = 1'b0; stall = 1'b1;
        check(fetch_addr, 32'h0000_0100, "R9 priority over write");

        // R10: wrap at both ends of the address space
        load_pc(32'hFFFF_FFFC);
        check(pc_operand, 32'h0, "R10 operand wraps");
        exec(5'd8, 9'd3, 9'd0, 32'd0, 32'd0, 32'd0, 32'h0, "R10 step wraps");
        exec(5'b01011, 9'd3, 9'h1FE, 32'd0, 32'd0, 32'd0, 32'hFFFF_FFFC, "R10 branch wraps");

        finish_run();
    end

endmodule